// File: doc/BRIEF.md
# Daisy-Chained Bus Grant Arbiter

This block lets a set of devices share one bus by passing a single serial grant signal along a chain. A central arbiter watches a shared request line and, when the bus is free, raises the grant at the head of the chain. The grant enters the device in position 0 first and moves toward the last position. A device that is not waiting passes the grant on without a register in the path. A device that is waiting takes the bus on a rising edge of its incoming grant. From that cycle on it blocks the grant from every device behind it.

Each device has a level input `want` and a one-cycle `done` input from its host logic, and an ownership flag. The shared request and release lines are modelled as a logical OR across all devices. When the owner pulses `done`, the arbiter withdraws the grant and keeps it low for at least one cycle. Every new owner therefore sees a fresh rising edge. A grant that reaches the end of the chain without being taken is also withdrawn, so a request that goes away cannot leave the grant stuck high.

Top module: `daisy_grant_bus`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `owns`, `grant_root`, `req_bus` and `rel_bus` are all 0.
- R2: `req_bus` is 1 exactly when some device i has `want[i]`=1, does not own the bus and is not taking it in that cycle.
- R3: If the grant is low and `req_bus` is 1 at a clock edge, `grant_root` is 1 after that edge. The waiting device takes the bus in that cycle and its `owns` bit is 1 after the next edge.
- R4: Bit i of `want`, `done` and `owns` belongs to device i, and device 0 has the highest priority. When several devices wait for the same rising grant, the lowest index takes it.
- R5: A device that owns the bus does not drive `req_bus`. A `done` pulse from the owner drives `rel_bus` high in the same cycle.
- R6: At most one bit of `owns` is 1 in any cycle, and while any bit is 1, `grant_root` is 1.
- R7: A `done` pulse from a device that does not own the bus leaves `rel_bus` at 0 and `owns` unchanged.
- R8: After a cycle with `rel_bus`=1, `grant_root` and `owns` are 0. The grant stays low for at least that one cycle before it can rise again.
- R9: A device that starts waiting while a lower-priority device owns the bus does not take the bus or break the grant held by the owner. It gets the bus only on the next rising edge.
- R10: If the grant is high and no device takes it, the grant reaches the end of the chain and `grant_root` falls after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| want | input | N_DEV | Per-device request level from host logic |
| done | input | N_DEV | Per-device end-of-use pulse |
| owns | output | N_DEV | Per-device bus ownership flag |
| grant_root | output | 1 | Grant driven by the arbiter into the head of the chain |
| req_bus | output | 1 | Shared request line (OR of device requests) |
| rel_bus | output | 1 | Shared release line (OR of device releases) |

## Verification
Two events can fall in the same cycle: the owner releasing the bus, and another device starting or keeping up its request. The bench raises a request from a higher-priority device while a lower one owns the bus, and it releases the bus while several devices are still waiting. It then checks that the grant drops for one cycle and rises again, and that only the highest-priority waiting device takes it. In the cycle a device takes the bus, the bench also checks that a device further down the chain sees no grant and keeps its request up.

// File: rtl/dgb_pkg.sv
package dgb_pkg;

    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_HELD = 1'b1
    } arb_state_e;

    typedef struct packed {
        logic req;
        logic rel;
        logic own;
    } slice_out_t;

    // bits below position idx set: the devices ahead of idx in the chain
    function automatic logic [31:0] ahead_mask(input int idx);
        logic [31:0] m;
        m = '0;
        for (int k = 0; k < 32; k++) begin
            if (k < idx) m[k] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/dgb_arbiter.sv
module dgb_arbiter
    import dgb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_bus,
    input  logic rel_bus,
    input  logic tail_grant,
    output logic grant
);

    arb_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ARB_IDLE;
        end else begin
            case (state_q)
                ARB_IDLE: if (req_bus) state_q <= ARB_HELD;
                ARB_HELD: if (rel_bus || tail_grant) state_q <= ARB_IDLE;
                default:  state_q <= ARB_IDLE;
            endcase
        end
    end

    assign grant = (state_q == ARB_HELD);

endmodule

// File: rtl/dgb_slice.sv
module dgb_slice
    import dgb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       grant_in,
    input  logic       want,
    input  logic       done,
    output logic       grant_out,
    output slice_out_t so
);

    logic grant_q;
    logic owned_q;
    logic take;

    assign take      = want && grant_in && !grant_q && !owned_q;
    assign grant_out = grant_in && !(owned_q || take);

    assign so.req = want && !owned_q && !take;
    assign so.rel = owned_q && done;
    assign so.own = owned_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= 1'b0;
            owned_q <= 1'b0;
        end else begin
            grant_q <= grant_in;
            if (take)
                owned_q <= 1'b1;
            else if (owned_q && done)
                owned_q <= 1'b0;
        end
    end

endmodule

// File: rtl/dgb_chain.sv
module dgb_chain
    import dgb_pkg::*;
#(
    parameter int N_DEV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             grant_head,
    input  logic [N_DEV-1:0] want,
    input  logic [N_DEV-1:0] done,
    output logic [N_DEV-1:0] owns,
    output logic             req_bus,
    output logic             rel_bus,
    output logic             tail_grant
);

    localparam int N_LINKS = N_DEV + 1;

    logic [N_LINKS-1:0] link;
    logic [N_DEV-1:0]   req_v;
    logic [N_DEV-1:0]   rel_v;

    assign link[0] = grant_head;

    for (genvar i = 0; i < N_DEV; i++) begin : g_dev
        slice_out_t so_i;
        dgb_slice u_slice (
            .clk      (clk),
            .rst      (rst),
            .grant_in (link[i]),
            .want     (want[i]),
            .done     (done[i]),
            .grant_out(link[i+1]),
            .so       (so_i)
        );
        assign req_v[i] = so_i.req;
        assign rel_v[i] = so_i.rel;
        assign owns[i]  = so_i.own;
    end

    assign req_bus    = |req_v;
    assign rel_bus    = |rel_v;
    assign tail_grant = link[N_DEV];

endmodule

// File: rtl/daisy_grant_bus.sv
module daisy_grant_bus
    import dgb_pkg::*;
#(
    parameter int N_DEV = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_DEV-1:0] want,
    input  logic [N_DEV-1:0] done,
    output logic [N_DEV-1:0] owns,
    output logic             grant_root,
    output logic             req_bus,
    output logic             rel_bus
);

    logic tail_grant;

    dgb_arbiter u_arb (
        .clk       (clk),
        .rst       (rst),
        .req_bus   (req_bus),
        .rel_bus   (rel_bus),
        .tail_grant(tail_grant),
        .grant     (grant_root)
    );

    dgb_chain #(.N_DEV(N_DEV)) u_chain (
        .clk       (clk),
        .rst       (rst),
        .grant_head(grant_root),
        .want      (want),
        .done      (done),
        .owns      (owns),
        .req_bus   (req_bus),
        .rel_bus   (rel_bus),
        .tail_grant(tail_grant)
    );

endmodule

// File: rtl/dgb_bus_chk.sv
module dgb_bus_chk
    import dgb_pkg::*;
#(
    parameter int N_DEV = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [N_DEV-1:0] want,
    input logic [N_DEV-1:0] done,
    input logic [N_DEV-1:0] owns,
    input logic             grant_root,
    input logic             req_bus,
    input logic             rel_bus
);

    // R6
    single_owner_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(owns));

    // R6
    owner_has_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (owns != '0) |-> grant_root);

    // R8
    release_clears_chk: assert property (@(posedge clk) disable iff (rst)
        rel_bus |=> (!grant_root && owns == '0));

    // R3
    fresh_edge_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(owns) == 1 && $past(owns) == '0) |-> $past($rose(grant_root)));

    // R7
    stray_done_chk: assert property (@(posedge clk) disable iff (rst)
        (owns == '0) |-> !rel_bus);

    for (genvar i = 0; i < N_DEV; i++) begin : g_prio
        localparam logic [31:0] AHEAD = ahead_mask(i);
        // R4
        priority_order_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(owns[i]) |-> (($past(want) & AHEAD[N_DEV-1:0]) == '0));
    end

endmodule

bind daisy_grant_bus dgb_bus_chk #(.N_DEV(N_DEV)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .want      (want),
    .done      (done),
    .owns      (owns),
    .grant_root(grant_root),
    .req_bus   (req_bus),
    .rel_bus   (rel_bus)
);

// File: tb/sim_daisy_grant_bus.sv
module sim_daisy_grant_bus;

    localparam int N = 4;
    localparam int NV = 21;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] want = '0;
    logic [N-1:0] done = '0;
    logic [N-1:0] owns;
    logic         grant_root, req_bus, rel_bus;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    daisy_grant_bus #(.N_DEV(N)) u0 (
        .clk(clk), .rst(rst), .want(want), .done(done),
        .owns(owns), .grant_root(grant_root), .req_bus(req_bus), .rel_bus(rel_bus)
    );

    // {want, done, owns, grant, req, rel}; each row checked before the next edge
    localparam logic [14:0] VEC [NV] = '{
        {4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0},
        {4'b0100, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0},
        {4'b0100, 4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0},
        {4'b0101, 4'b0000, 4'b0100, 1'b1, 1'b1, 1'b0},
        {4'b0101, 4'b0001, 4'b0100, 1'b1, 1'b1, 1'b0},
        {4'b0101, 4'b0100, 4'b0100, 1'b1, 1'b1, 1'b1},
        {4'b0001, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0},
        {4'b0001, 4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0},
        {4'b0011, 4'b0000, 4'b0001, 1'b1, 1'b1, 1'b0},
        {4'b0011, 4'b0001, 4'b0001, 1'b1, 1'b1, 1'b1},
        {4'b0010, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0},
        {4'b0010, 4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0},
        {4'b0010, 4'b0010, 4'b0010, 1'b1, 1'b0, 1'b1},
        {4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0},
        {4'b1010, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0},
        {4'b1010, 4'b0000, 4'b0000, 1'b1, 1'b1, 1'b0},
        {4'b1010, 4'b0010, 4'b0010, 1'b1, 1'b1, 1'b1},
        {4'b1000, 4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0},
        {4'b1000, 4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0},
        {4'b1000, 4'b1000, 4'b1000, 1'b1, 1'b0, 1'b1},
        {4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0}
    };

    function automatic string row_tag(input int r);
        case (r)
            0:              return "R1 idle after reset";
            1, 8, 14:       return "R2 shared request";
            2, 7, 11:       return "R3 grant and take";
            3:              return "R9 late higher requester";
            4:              return "R7 stray done";
            5, 9, 12, 16,
            19:             return "R5 owner release";
            6, 10, 17:      return "R8 grant low after release";
            15, 18:         return "R4 chain priority";
            default:        return "R6 single owner";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic look(input string tag, input logic [N-1:0] e_own, input logic e_g,
                        input logic e_req, input logic e_rel);
        #2;
        chk(tag, {28'd0, owns}, {28'd0, e_own});
        chk(tag, {29'd0, grant_root, req_bus, rel_bus}, {29'd0, e_g, e_req, e_rel});
    endtask

    initial begin
        #200000000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs during reset
        look("R1 during reset", 4'b0000, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;

        for (int r = 0; r < NV; r++) begin
            @(negedge clk);
            want = VEC[r][14:11];
            done = VEC[r][10:7];
            look(row_tag(r), VEC[r][6:3], VEC[r][2], VEC[r][1], VEC[r][0]);
        end

        // R4: all four wait together, device 0 wins, then device 1
        @(negedge clk); want = 4'b1111; done = '0;
        look("R4 all request", 4'b0000, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        look("R4 all request take", 4'b0000, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        look("R4 device 0 wins", 4'b0001, 1'b1, 1'b1, 1'b0);
        done = 4'b0001;
        look("R5 release with waiters", 4'b0001, 1'b1, 1'b1, 1'b1);
        @(negedge clk); done = '0; want = 4'b1110;
        look("R8 gap before regrant", 4'b0000, 1'b0, 1'b1, 1'b0);
        @(negedge clk);
        look("R8 regrant rises", 4'b0000, 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        look("R4 device 1 next", 4'b0010, 1'b1, 1'b1, 1'b0);
        want = '0; done = 4'b0010;
        @(negedge clk); done = '0;
        look("R8 idle after last release", 4'b0000, 1'b0, 1'b0, 1'b0);

        // R10: request withdrawn before the grant is taken
        @(negedge clk); want = 4'b0100;
        @(negedge clk); want = '0;
        look("R10 unclaimed grant high", 4'b0000, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        look("R10 unclaimed grant withdrawn", 4'b0000, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        look("R10 stays low", 4'b0000, 1'b0, 1'b0, 1'b0);

        // R1: reset while a device owns the bus
        want = 4'b0001;
        @(negedge clk);
        @(negedge clk);
        look("R1 owner before reset", 4'b0001, 1'b1, 1'b0, 1'b0);
        rst = 1'b1; want = '0;
        @(negedge clk);
        look("R1 reset clears owner", 4'b0000, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        look("R1 after reset", 4'b0000, 1'b0, 1'b0, 1'b0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule